// File: doc/BRIEF.md
# Cascaded Programmable System Timebase

This block turns the system clock into a set of programmable time ticks for a small 8-bit microcontroller. Two software-loaded dividers run from the clock: one gives a microsecond tick and one gives a millisecond tick. Further counters run from the millisecond tick and produce a hundred-millisecond tick, a one-second tick, a millisecond interrupt every N milliseconds, and a watchdog. A 4-bit flash-timing input divides the microsecond tick into a strobe that flash-write logic elsewhere can use. The length of each tick depends only on the clock rate and the loaded values, so software sets a "microsecond" or "millisecond" to suit whatever clock the chip runs from.

Software sees six byte registers at consecutive addresses from a base (default 0xFA), on a plain bus with address, write data, write and read strobes. Every divider counts down from its value minus one. When it reaches terminal count it reloads, so a value of N gives one output every N input ticks, and a value of zero stops that stage. Writing a divider register restarts its stage. The two interrupts are sticky flags in the control register, and software clears each by writing 1 to it. Once the watchdog is enabled, software must keep restarting it. If restarts stop, the watchdog raises a reset line that stays high until system reset.

Top module: `sys_timebase`

## Requirements
- R1: Registers sit at base+0 to base+5 in the order: millisecond-interrupt count, microsecond divider, millisecond divider low byte, millisecond divider high byte, hundred-millisecond count, control. All reset to 0 and read back the value written. The control register reads bit 7 enable, bit 6 as 0, bit 5 ms flag, bit 4 second flag, and bits 3:0 the watchdog limit.
- R2: `us_tick` pulses once every U clocks, where U is the microsecond divider. U = 0 gives no tick.
- R3: `ms_tick` pulses once every M clocks, where M is the 16-bit value {high byte, low byte}. M = 0 gives no tick.
- R4: `flash_strobe` pulses once every F microsecond ticks, where F is `flash_tsel`, and only in a cycle with `us_tick`.
- R5: `hms_tick` pulses once every H millisecond ticks, where H is the hundred-millisecond count, and only in a cycle with `ms_tick`.
- R6: `sec_tick` pulses once every 10 hundred-millisecond ticks, and only in a cycle with `hms_tick`.
- R7: Control bit 5 and `irq_ms` set once every K millisecond ticks, where K is the millisecond-interrupt count. Writing 1 to bit 5 clears them. K = 0 never sets them.
- R8: Control bit 4 and `irq_sec` set on each second tick. Writing 1 to bit 4 clears them.
- R9: Writing a divider register restarts that stage. The first tick after the write comes exactly N clocks after the write edge.
- R10: With bit 7 set and limit L (bits 3:0) nonzero, `wdt_reset` rises on the edge after the L-th hundred-millisecond tick since the last restart or enable. It then stays high until reset. With the watchdog disabled, or with L = 0, it never rises.
- R11: Writing 1 to bit 6 restarts the watchdog count, and the bit reads back as 0. Restarts that come more often than the timeout keep `wdt_reset` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; read data is combinational |
| bus_rdata | output | 8 | Read data, 0 when not reading a register |
| flash_tsel | input | 4 | Microsecond ticks per flash strobe |
| us_tick | output | 1 | Microsecond tick |
| ms_tick | output | 1 | Millisecond tick |
| hms_tick | output | 1 | Hundred-millisecond tick |
| sec_tick | output | 1 | One-second tick |
| flash_strobe | output | 1 | Flash-write timing strobe |
| irq_ms | output | 1 | Millisecond interrupt request (sticky) |
| irq_sec | output | 1 | Second interrupt request (sticky) |
| wdt_reset | output | 1 | Watchdog system reset request |

## Verification
The nesting properties (flash within microsecond, hundred-ms within ms, second within hundred-ms) assume that `flash_tsel` changes only while the microsecond divider is rewritten or stopped. Without that, a stale count could outlast a shorter new value. The bench sets `flash_tsel` once, before it loads the microsecond divider. Each bus access is a single write or read pulse, never both at once. The watchdog-cause property assumes the enable bit is not cleared in the cycle of a timeout, and the stimulus only restarts or re-enables the watchdog between timeouts.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
  localparam int REG_COUNT = 6;

  typedef enum logic [2:0] {
    OFS_MSINT = 3'd0,
    OFS_USDIV = 3'd1,
    OFS_MSLO  = 3'd2,
    OFS_MSHI  = 3'd3,
    OFS_HMS   = 3'd4,
    OFS_WDCTL = 3'd5
  } tb_reg_e;

  localparam int CTL_EN      = 7;
  localparam int CTL_KICK    = 6;
  localparam int CTL_MSFLAG  = 5;
  localparam int CTL_SECFLAG = 4;

  // watchdog terminal test: the next counted tick reaches the limit
  function automatic logic wdt_hit(input logic [3:0] cnt, input logic [3:0] lim);
    return (lim != 4'd0) && (({1'b0, cnt} + 5'd1) == {1'b0, lim});
  endfunction
endpackage

// File: rtl/tbase_divider.sv
module tbase_divider #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_in,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] cfg,
  output logic         tick_out
);
  logic [W-1:0] cnt;

  function automatic logic [W-1:0] reload(input logic [W-1:0] v);
    return (v == '0) ? '0 : v - W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= reload(load_val);
    end else if (tick_in && cfg != '0) begin
      cnt <= (cnt == '0) ? reload(cfg) : cnt - W'(1);
    end
  end

  assign tick_out = tick_in && (cfg != '0) && (cnt == '0);
endmodule

// File: rtl/tbase_watchdog.sv
module tbase_watchdog import tbase_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [3:0] limit,
  input  logic       kick,
  input  logic       hms_tick,
  output logic       wdt_reset
);
  logic [3:0] cnt;
  logic       expire;

  assign expire = en && !kick && hms_tick && wdt_hit(cnt, limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      wdt_reset <= 1'b0;
    end else begin
      if (!en || kick)                cnt <= '0;
      else if (hms_tick && !wdt_reset) cnt <= cnt + 4'd1;
      if (expire) wdt_reset <= 1'b1;
    end
  end
endmodule

// File: rtl/tbase_regs.sv
module tbase_regs import tbase_pkg::*; #(
  parameter logic [7:0] BASE = 8'hFA
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  addr,
  input  logic [7:0]  wdata,
  input  logic        wr,
  input  logic        rd,
  output logic [7:0]  rdata,
  input  logic        ev_ms,
  input  logic        ev_sec,
  output logic [7:0]  msint_q,
  output logic [7:0]  usdiv_q,
  output logic [15:0] msdiv_q,
  output logic [7:0]  hms_q,
  output logic [7:0]  msint_d,
  output logic [7:0]  usdiv_d,
  output logic [15:0] msdiv_d,
  output logic [7:0]  hms_d,
  output logic        ld_msint,
  output logic        ld_us,
  output logic        ld_ms,
  output logic        ld_hms,
  output logic        wd_en,
  output logic [3:0]  wd_lim,
  output logic        wd_kick,
  output logic        flag_ms,
  output logic        flag_sec
);
  logic [7:0] ofs;
  logic       hit;
  logic       wr_lo, wr_hi, wr_ctl;

  assign ofs = addr - BASE;
  assign hit = (ofs < 8'(REG_COUNT));

  assign ld_msint = wr && hit && (ofs[2:0] == OFS_MSINT);
  assign ld_us    = wr && hit && (ofs[2:0] == OFS_USDIV);
  assign wr_lo    = wr && hit && (ofs[2:0] == OFS_MSLO);
  assign wr_hi    = wr && hit && (ofs[2:0] == OFS_MSHI);
  assign ld_hms   = wr && hit && (ofs[2:0] == OFS_HMS);
  assign wr_ctl   = wr && hit && (ofs[2:0] == OFS_WDCTL);
  assign ld_ms    = wr_lo || wr_hi;
  assign wd_kick  = wr_ctl && wdata[CTL_KICK];

  assign msint_d = ld_msint ? wdata : msint_q;
  assign usdiv_d = ld_us ? wdata : usdiv_q;
  assign hms_d   = ld_hms ? wdata : hms_q;
  assign msdiv_d = {wr_hi ? wdata : msdiv_q[15:8], wr_lo ? wdata : msdiv_q[7:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msint_q  <= '0;
      usdiv_q  <= '0;
      msdiv_q  <= '0;
      hms_q    <= '0;
      wd_en    <= 1'b0;
      wd_lim   <= '0;
      flag_ms  <= 1'b0;
      flag_sec <= 1'b0;
    end else begin
      msint_q <= msint_d;
      usdiv_q <= usdiv_d;
      msdiv_q <= msdiv_d;
      hms_q   <= hms_d;
      if (wr_ctl) begin
        wd_en  <= wdata[CTL_EN];
        wd_lim <= wdata[3:0];
      end
      // a new event wins over a same-cycle clear
      flag_ms  <= ev_ms  || (flag_ms  && !(wr_ctl && wdata[CTL_MSFLAG]));
      flag_sec <= ev_sec || (flag_sec && !(wr_ctl && wdata[CTL_SECFLAG]));
    end
  end

  always_comb begin
    rdata = '0;
    if (rd && hit) begin
      case (ofs[2:0])
        OFS_MSINT: rdata = msint_q;
        OFS_USDIV: rdata = usdiv_q;
        OFS_MSLO:  rdata = msdiv_q[7:0];
        OFS_MSHI:  rdata = msdiv_q[15:8];
        OFS_HMS:   rdata = hms_q;
        OFS_WDCTL: rdata = {wd_en, 1'b0, flag_ms, flag_sec, wd_lim};
        default:   rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/sys_timebase.sv
module sys_timebase import tbase_pkg::*; #(
  parameter logic [7:0] BASE_ADDR = 8'hFA,
  parameter int         SEC_DIV   = 10,
  parameter int         FLASH_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [7:0]         bus_addr,
  input  logic [7:0]         bus_wdata,
  input  logic               bus_wr,
  input  logic               bus_rd,
  output logic [7:0]         bus_rdata,
  input  logic [FLASH_W-1:0] flash_tsel,
  output logic               us_tick,
  output logic               ms_tick,
  output logic               hms_tick,
  output logic               sec_tick,
  output logic               flash_strobe,
  output logic               irq_ms,
  output logic               irq_sec,
  output logic               wdt_reset
);
  localparam int SEC_W = $clog2(SEC_DIV + 1);

  logic [7:0]  msint_q, us_div_q, hms_q;
  logic [7:0]  msint_d, us_div_d, hms_d;
  logic [15:0] ms_div_q, ms_div_d;
  logic        ld_msint, ld_us, ld_ms, ld_hms;
  logic        wd_en, wd_kick;
  logic [3:0]  wd_lim;
  logic        msint_tick;

  tbase_regs #(.BASE(BASE_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata),
    .wr(bus_wr), .rd(bus_rd), .rdata(bus_rdata),
    .ev_ms(msint_tick), .ev_sec(sec_tick),
    .msint_q(msint_q), .usdiv_q(us_div_q), .msdiv_q(ms_div_q), .hms_q(hms_q),
    .msint_d(msint_d), .usdiv_d(us_div_d), .msdiv_d(ms_div_d), .hms_d(hms_d),
    .ld_msint(ld_msint), .ld_us(ld_us), .ld_ms(ld_ms), .ld_hms(ld_hms),
    .wd_en(wd_en), .wd_lim(wd_lim), .wd_kick(wd_kick),
    .flag_ms(irq_ms), .flag_sec(irq_sec)
  );

  tbase_divider #(.W(8)) u_us (
    .clk(clk), .rst_n(rst_n), .tick_in(1'b1), .load(ld_us),
    .load_val(us_div_d), .cfg(us_div_q), .tick_out(us_tick)
  );

  tbase_divider #(.W(FLASH_W)) u_flash (
    .clk(clk), .rst_n(rst_n), .tick_in(us_tick), .load(ld_us),
    .load_val(flash_tsel), .cfg(flash_tsel), .tick_out(flash_strobe)
  );

  tbase_divider #(.W(16)) u_ms (
    .clk(clk), .rst_n(rst_n), .tick_in(1'b1), .load(ld_ms),
    .load_val(ms_div_d), .cfg(ms_div_q), .tick_out(ms_tick)
  );

  tbase_divider #(.W(8)) u_msint (
    .clk(clk), .rst_n(rst_n), .tick_in(ms_tick), .load(ld_msint),
    .load_val(msint_d), .cfg(msint_q), .tick_out(msint_tick)
  );

  tbase_divider #(.W(8)) u_hms (
    .clk(clk), .rst_n(rst_n), .tick_in(ms_tick), .load(ld_hms),
    .load_val(hms_d), .cfg(hms_q), .tick_out(hms_tick)
  );

  tbase_divider #(.W(SEC_W)) u_sec (
    .clk(clk), .rst_n(rst_n), .tick_in(hms_tick), .load(1'b0),
    .load_val('0), .cfg(SEC_W'(SEC_DIV)), .tick_out(sec_tick)
  );

  tbase_watchdog u_wdt (
    .clk(clk), .rst_n(rst_n), .en(wd_en), .limit(wd_lim), .kick(wd_kick),
    .hms_tick(hms_tick), .wdt_reset(wdt_reset)
  );
endmodule

// File: rtl/sys_timebase_chk.sv
module sys_timebase_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        us_tick,
  input logic        ms_tick,
  input logic        hms_tick,
  input logic        sec_tick,
  input logic        flash_strobe,
  input logic        irq_ms,
  input logic        irq_sec,
  input logic        wdt_reset,
  input logic [7:0]  us_div,
  input logic [15:0] ms_div,
  input logic        msint_tick,
  input logic        wd_en
);
  p_us_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (us_div == 8'd0) |-> !us_tick);
  p_ms_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ms_div == 16'd0) |-> !ms_tick);
  p_flash_on_us_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flash_strobe |-> us_tick);
  p_hms_on_ms_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hms_tick |-> ms_tick);
  p_sec_on_hms_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |-> hms_tick);
  p_msint_on_ms_r7: assert property (@(posedge clk) disable iff (!rst_n)
    msint_tick |-> ms_tick);
  p_irq_ms_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_ms) |-> $past(msint_tick));
  p_irq_sec_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_sec) |-> $past(sec_tick));
  p_wdt_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset |=> wdt_reset);
  p_wdt_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_reset) |-> $past(hms_tick && wd_en));
endmodule

bind sys_timebase sys_timebase_chk u_chk (
  .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .ms_tick(ms_tick),
  .hms_tick(hms_tick), .sec_tick(sec_tick), .flash_strobe(flash_strobe),
  .irq_ms(irq_ms), .irq_sec(irq_sec), .wdt_reset(wdt_reset),
  .us_div(us_div_q), .ms_div(ms_div_q), .msint_tick(msint_tick), .wd_en(wd_en)
);

// File: tb/sys_timebase_test.sv
module sys_timebase_test;
  localparam logic [7:0] A_MSINT = 8'hFA, A_US = 8'hFB, A_MSLO = 8'hFC,
                         A_MSHI = 8'hFD, A_HMS = 8'hFE, A_CTL = 8'hFF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0] flash_tsel = '0;
  logic us_tick, ms_tick, hms_tick, sec_tick, flash_strobe, irq_ms, irq_sec, wdt_reset;

  int n_checks = 0, n_err = 0, cyc = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sys_timebase uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .flash_tsel(flash_tsel),
    .us_tick(us_tick), .ms_tick(ms_tick), .hms_tick(hms_tick), .sec_tick(sec_tick),
    .flash_strobe(flash_strobe), .irq_ms(irq_ms), .irq_sec(irq_sec), .wdt_reset(wdt_reset)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  // scoreboard of expected tick periods
  typedef struct { int sel; int period; string req; } exp_t;
  exp_t sb[$];
  bit mon_busy = 1'b0;

  function automatic logic tick_of(input int s);
    case (s)
      0: return us_tick;
      1: return ms_tick;
      2: return hms_tick;
      3: return sec_tick;
      default: return flash_strobe;
    endcase
  endfunction

  task automatic expect_period(input int s, input int p, input string req, input int reps);
    for (int i = 0; i < reps; i++) begin
      exp_t e;
      e.sel = s; e.period = p; e.req = req;
      sb.push_back(e);
    end
    wait (sb.size() == 0 && !mon_busy);
  endtask

  initial begin
    forever begin
      exp_t e;
      int n;
      wait (sb.size() > 0);
      mon_busy = 1'b1;
      e = sb.pop_front();
      @(negedge clk);
      n = 0;
      while (!tick_of(e.sel) && n < 20000) begin @(negedge clk); n++; end
      n = 0;
      do begin @(negedge clk); n++; end while (!tick_of(e.sel) && n < 20000);
      chk(n == e.period, e.req, n, e.period);
      mon_busy = 1'b0;
    end
  end

  // interrupt rise recorder
  int ms_rise_n = 0, ms_rise_t = 0, sec_rise_n = 0, sec_rise_t = 0;
  logic prev_ms = 1'b0, prev_sec = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (irq_ms && !prev_ms) begin ms_rise_n++; ms_rise_t = cyc; end
    if (irq_sec && !prev_sec) begin sec_rise_n++; sec_rise_t = cyc; end
    prev_ms = irq_ms;
    prev_sec = irq_sec;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int n0, t1, k, seen;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd(A_US, d);   chk(d == 8'h00, "R1 reset usdiv", d, 0);
    rd(A_CTL, d);  chk(d == 8'h00, "R1 reset ctl", d, 0);
    chk({us_tick, ms_tick, irq_ms, irq_sec, wdt_reset} == 5'b0, "R1 reset outputs",
        {us_tick, ms_tick, irq_ms, irq_sec, wdt_reset}, 0);

    // R2: zero divider stops the microsecond tick
    seen = 0;
    repeat (40) begin @(negedge clk); if (us_tick) seen++; end
    chk(seen == 0, "R2 stopped us", seen, 0);

    flash_tsel = 4'd4;
    wr(A_US, 8'd5);
    wr(A_MSLO, 8'h03);
    wr(A_MSHI, 8'h01);
    rd(A_US, d);   chk(d == 8'd5, "R1 readback usdiv", d, 5);
    rd(A_MSLO, d); chk(d == 8'h03, "R1 readback mslo", d, 3);
    rd(A_MSHI, d); chk(d == 8'h01, "R1 readback mshi", d, 1);
    rd(A_HMS, d);  chk(d == 8'h00, "R1 readback hms", d, 0);

    expect_period(0, 5, "R2 us period", 3);
    expect_period(4, 20, "R4 flash period", 2);
    expect_period(1, 259, "R3 ms period 16-bit", 2);

    wr(A_MSHI, 8'h00);
    wr(A_MSLO, 8'd19);
    expect_period(1, 19, "R3 ms period", 2);
    wr(A_HMS, 8'd3);
    expect_period(2, 57, "R5 hms period", 2);
    expect_period(3, 570, "R6 sec period", 2);

    // R7: millisecond interrupt every 4 ms ticks = 76 clocks
    wr(A_MSINT, 8'd4);
    rd(A_MSINT, d); chk(d == 8'd4, "R1 readback msint", d, 4);
    wr(A_CTL, 8'h20);
    n0 = ms_rise_n; wait (ms_rise_n != n0); t1 = ms_rise_t;
    rd(A_CTL, d); chk(d[5] == 1'b1, "R7 flag bit5 set", d, 8'h20);
    wr(A_CTL, 8'h20);
    chk(irq_ms == 1'b0, "R7 write-1 clears", irq_ms, 0);
    n0 = ms_rise_n; wait (ms_rise_n != n0);
    chk(ms_rise_t - t1 == 76, "R7 interrupt interval", ms_rise_t - t1, 76);

    // R8: second interrupt
    wr(A_CTL, 8'h10);
    n0 = sec_rise_n; wait (sec_rise_n != n0); t1 = sec_rise_t;
    rd(A_CTL, d); chk(d[4] == 1'b1, "R8 flag bit4 set", d, 8'h10);
    wr(A_CTL, 8'h10);
    chk(irq_sec == 1'b0, "R8 write-1 clears", irq_sec, 0);
    n0 = sec_rise_n; wait (sec_rise_n != n0);
    chk(sec_rise_t - t1 == 570, "R8 interrupt interval", sec_rise_t - t1, 570);

    // R7: zero count never sets
    wr(A_MSINT, 8'd0);
    wr(A_CTL, 8'h20);
    repeat (200) @(negedge clk);
    chk(irq_ms == 1'b0, "R7 zero count no irq", irq_ms, 0);
    chk(wdt_reset == 1'b0, "R10 disabled no reset", wdt_reset, 0);

    // R9: restart on divider write
    wr(A_US, 8'd5);
    k = 1; seen = 0;
    while (!us_tick && k < 50) begin @(negedge clk); k++; end
    chk(k == 5, "R9 us restart", k, 5);
    wr(A_MSLO, 8'd19);
    k = 1;
    while (!ms_tick && k < 100) begin @(negedge clk); k++; end
    chk(k == 19, "R9 ms restart", k, 19);

    // R10: limit zero never times out
    wr(A_CTL, 8'h80);
    repeat (400) @(negedge clk);
    chk(wdt_reset == 1'b0, "R10 limit zero", wdt_reset, 0);

    // R11: regular restarts keep reset low (timeout 3 x 57 clocks)
    wr(A_CTL, 8'hC3);
    rd(A_CTL, d); chk((d & 8'hCF) == 8'h83, "R11 kick reads 0", d & 8'hCF, 8'h83);
    for (int i = 0; i < 12; i++) begin
      repeat (100) @(negedge clk);
      wr(A_CTL, 8'hC3);
    end
    chk(wdt_reset == 1'b0, "R11 kept alive", wdt_reset, 0);

    // R10: timeout when restarts stop, window [115,171]
    wr(A_CTL, 8'hC3);
    k = 1;
    while (!wdt_reset && k < 400) begin @(negedge clk); k++; end
    chk(k >= 115 && k <= 171, "R10 timeout window", k, 171);
    repeat (30) @(negedge clk);
    chk(wdt_reset == 1'b1, "R10 reset held", wdt_reset, 1);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end
endmodule